// File: doc/BRIEF.md
# Protection Mode Mismatch Detector

This block watches the low nibble of the received K2 overhead byte once per frame. It compares that nibble with the protection setup provisioned on this node. Bit 3 of the nibble reports the far end's architecture: 0 means 1+1 and 1 means 1:n. It is checked against a local architecture bit. Bits 2..0 report the far end's switching direction: 101 means bidirectional and 100 means unidirectional. They are checked against a local direction bit. A frame is a mismatch frame if the architecture bit differs, or if the direction field carries the opposite direction code. Any other direction value is not a direction mismatch. This includes the line AIS code 111 and the line RDI code 110.

The condition is filtered before it is reported. The defect is raised once the condition has held for a run of consecutive frames, and it is dropped once the condition has been absent for a run of the same length. The run length is 3 frames or 5 frames, chosen by a select input. Each time the defect changes state, a sticky status flag is set. The flag drives an interrupt unless the interrupt is masked. A global mode input decides how the flag is cleared: by a read strobe or by a write strobe.

Top module: `aps_mm_det`

## Requirements
- R1: During and right after reset, `mm_defect`, `mm_sts` and `mm_irq` are all 0.
- R2: A frame whose K2 bit 3 differs from `cfg_arch` (0 = 1+1, 1 = 1:n) is a mismatch frame.
- R3: With `cfg_dir` = 0 (bidirectional), a frame is a mismatch frame when K2 bits [2:0] = 100. With `cfg_dir` = 1 (unidirectional), a frame is a mismatch frame when K2 bits [2:0] = 101.
- R4: When K2 bit 3 matches `cfg_arch`, every bits [2:0] value other than the opposite direction code (including 111 and 110) is a clean frame.
- R5: `mm_defect` rises on the clock edge that samples the Nth consecutive mismatch frame and not before. N = 3 when `cfg_short` = 1 and N = 5 when `cfg_short` = 0.
- R6: A clean frame in the middle of a mismatch run restarts the count, and the reverse holds while the defect is set.
- R7: `mm_defect` falls on the edge that samples the Nth consecutive clean frame.
- R8: Cycles with `frm_stb` = 0 have no effect on the defect, whatever `k2_byte` holds.
- R9: `mm_sts` is set on the same edge at which `mm_defect` changes, in either direction.
- R10: `mm_irq` equals `mm_sts` AND NOT `irq_mask`.
- R11: With `clr_on_rd` = 1, `sts_rd` clears `mm_sts` and `sts_wr` is ignored. With `clr_on_rd` = 0, `sts_wr` clears it and `sts_rd` is ignored.
- R12: When a clear and a state change fall on the same edge, `mm_sts` ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_stb | input | 1 | One-cycle pulse when `k2_byte` holds a new frame's value |
| k2_byte | input | 8 | Received K2 byte; bits [3:0] are examined |
| cfg_arch | input | 1 | Provisioned architecture: 0 = 1+1, 1 = 1:n |
| cfg_dir | input | 1 | Provisioned direction: 0 = bidirectional (101), 1 = unidirectional (100) |
| cfg_short | input | 1 | Persistence: 1 = 3 frames, 0 = 5 frames |
| irq_mask | input | 1 | 1 masks the interrupt |
| clr_on_rd | input | 1 | Status clear mode: 1 = clear on read, 0 = clear on write |
| sts_rd | input | 1 | Status read strobe |
| sts_wr | input | 1 | Status write strobe |
| mm_defect | output | 1 | Filtered mode mismatch defect |
| mm_sts | output | 1 | Sticky flag, set on each defect change |
| mm_irq | output | 1 | Interrupt request |

## Verification
Two things can land on one clock edge: a defect transition, which sets the status flag, and a clear strobe from software, which resets it. The bench first leaves the flag set from an earlier transition. It then runs a filter count up to one frame short of the threshold and asserts the active clear strobe together with the final frame. The flag must read 1 afterwards. A lone clear strobe a few cycles later must then bring it to 0, which shows that the strobe itself was honoured.

// File: rtl/aps_mm_pkg.sv
package aps_mm_pkg;

    typedef enum logic {
        ARCH_ONE_PLUS_ONE = 1'b0,
        ARCH_ONE_FOR_N    = 1'b1
    } arch_e;

    typedef enum logic {
        DIR_BIDIR  = 1'b0,
        DIR_UNIDIR = 1'b1
    } dir_e;

    typedef struct packed {
        logic sts;
    } sts_state_t;

    // Code the far end sends for a given direction setting.
    function automatic logic [2:0] dir_code(input dir_e d,
                                            input logic [2:0] bidir_code,
                                            input logic [2:0] unidir_code);
        return (d == DIR_BIDIR) ? bidir_code : unidir_code;
    endfunction

endpackage

// File: rtl/aps_mm_cmp.sv
module aps_mm_cmp
    import aps_mm_pkg::*;
#(
    parameter logic [2:0] BIDIR_CODE  = 3'b101,
    parameter logic [2:0] UNIDIR_CODE = 3'b100
) (
    input  logic [3:0] nib_i,
    input  logic       arch_i,
    input  logic       dir_i,
    output logic       arch_mm_o,
    output logic       dir_mm_o,
    output logic       mm_o
);

    logic [2:0] opposite_code;

    always_comb begin
        // The code that would indicate the other direction than provisioned.
        opposite_code = dir_code(dir_e'(~dir_i), BIDIR_CODE, UNIDIR_CODE);
        arch_mm_o     = (nib_i[3] != arch_i);
        dir_mm_o      = (nib_i[2:0] == opposite_code);
        mm_o          = arch_mm_o | dir_mm_o;
    end

    always_comb begin
        if (dir_mm_o) begin
            AST_DIR_MM_CODE: assert (nib_i[2:0] == BIDIR_CODE || nib_i[2:0] == UNIDIR_CODE); // R4
        end
    end

endmodule

// File: rtl/aps_mm_persist.sv
module aps_mm_persist #(
    parameter int SHORT_FRM = 3,
    parameter int LONG_FRM  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic mm_i,
    input  logic short_i,
    output logic defect_o,
    output logic chg_o
);

    localparam int CW = $clog2(LONG_FRM + 1);
    localparam logic [CW-1:0] SHORT_THR = CW'(SHORT_FRM);
    localparam logic [CW-1:0] LONG_THR  = CW'(LONG_FRM);

    typedef struct packed {
        logic          defect;
        logic [CW-1:0] cnt;
    } pst_t;

    pst_t          st_d, st_q;
    logic [CW-1:0] thr;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        chg_o   = 1'b0;
        thr     = short_i ? SHORT_THR : LONG_THR;
        cnt_inc = st_q.cnt + CW'(1);
        if (stb_i) begin
            if (mm_i != st_q.defect) begin
                if (cnt_inc >= thr) begin
                    st_d.defect = mm_i;
                    st_d.cnt    = '0;
                    chg_o       = 1'b1;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign defect_o = st_q.defect;

    AST_NO_STB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(defect_o)); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < LONG_THR); // R5
    AST_RISE_NEEDS_MM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(defect_o) |-> $past(stb_i && mm_i)); // R5
    AST_FALL_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(defect_o) |-> $past(stb_i && !mm_i)); // R7

endmodule

// File: rtl/aps_mm_status.sv
module aps_mm_status
    import aps_mm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_on_rd_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic mask_i,
    output logic sts_o,
    output logic irq_o
);

    sts_state_t st_d, st_q;
    logic       clr_evt;

    always_comb begin
        st_d    = st_q;
        clr_evt = clr_on_rd_i ? rd_i : wr_i;
        if (set_i) begin
            st_d.sts = 1'b1;
        end else if (clr_evt) begin
            st_d.sts = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o = st_q.sts;
    assign irq_o = st_q.sts & ~mask_i;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> sts_o); // R12
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_i) |=> !sts_o); // R11
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |-> !irq_o); // R10

endmodule

// File: rtl/aps_mm_det.sv
module aps_mm_det #(
    parameter int         SHORT_FRM   = 3,
    parameter int         LONG_FRM    = 5,
    parameter logic [2:0] BIDIR_CODE  = 3'b101,
    parameter logic [2:0] UNIDIR_CODE = 3'b100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_stb,
    input  logic [7:0] k2_byte,
    input  logic       cfg_arch,
    input  logic       cfg_dir,
    input  logic       cfg_short,
    input  logic       irq_mask,
    input  logic       clr_on_rd,
    input  logic       sts_rd,
    input  logic       sts_wr,
    output logic       mm_defect,
    output logic       mm_sts,
    output logic       mm_irq
);

    logic arch_mm, dir_mm, frame_mm, chg;

    aps_mm_cmp #(
        .BIDIR_CODE (BIDIR_CODE),
        .UNIDIR_CODE(UNIDIR_CODE)
    ) u_cmp (
        .nib_i    (k2_byte[3:0]),
        .arch_i   (cfg_arch),
        .dir_i    (cfg_dir),
        .arch_mm_o(arch_mm),
        .dir_mm_o (dir_mm),
        .mm_o     (frame_mm)
    );

    aps_mm_persist #(
        .SHORT_FRM(SHORT_FRM),
        .LONG_FRM (LONG_FRM)
    ) u_persist (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (frm_stb),
        .mm_i    (frame_mm),
        .short_i (cfg_short),
        .defect_o(mm_defect),
        .chg_o   (chg)
    );

    aps_mm_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (chg),
        .clr_on_rd_i(clr_on_rd),
        .rd_i       (sts_rd),
        .wr_i       (sts_wr),
        .mask_i     (irq_mask),
        .sts_o      (mm_sts),
        .irq_o      (mm_irq)
    );

    AST_CHANGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_defect != $past(mm_defect)) |-> mm_sts); // R9
    AST_ARCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_stb && arch_mm && !dir_mm) |-> frame_mm); // R2

endmodule

// File: tb/tb_aps_mm_det.sv
module tb_aps_mm_det;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_stb = 1'b0;
    logic [7:0] k2_byte = 8'h00;
    logic       cfg_arch = 1'b0, cfg_dir = 1'b0, cfg_short = 1'b1;
    logic       irq_mask = 1'b0, clr_on_rd = 1'b1, sts_rd = 1'b0, sts_wr = 1'b0;
    logic       mm_defect, mm_sts, mm_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    aps_mm_det dut (
        .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .k2_byte(k2_byte),
        .cfg_arch(cfg_arch), .cfg_dir(cfg_dir), .cfg_short(cfg_short),
        .irq_mask(irq_mask), .clr_on_rd(clr_on_rd), .sts_rd(sts_rd),
        .sts_wr(sts_wr), .mm_defect(mm_defect), .mm_sts(mm_sts), .mm_irq(mm_irq)
    );

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        frm_stb = 1'b0; sts_rd = 1'b0; sts_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One frame; optional read/write strobe in the same cycle.
    task automatic frame(input logic [3:0] nib, input logic rd, input logic wr);
        @(negedge clk);
        frm_stb = 1'b1;
        k2_byte = {4'hA, nib};
        sts_rd = rd; sts_wr = wr;
        @(negedge clk);
        frm_stb = 1'b0; sts_rd = 1'b0; sts_wr = 1'b0;
        k2_byte = 8'h00;
    endtask

    task automatic pulse(input logic rd, input logic wr);
        @(negedge clk);
        sts_rd = rd; sts_wr = wr;
        @(negedge clk);
        sts_rd = 1'b0; sts_wr = 1'b0;
    endtask

    function automatic logic exp_mm(input logic [3:0] n, input logic a, input logic d);
        logic [2:0] other;
        other = d ? 3'd5 : 3'd4;
        return (n[3] != a) || (n[2:0] == other);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // R1 reset state
        repeat (2) @(negedge clk);
        check("R1 defect", mm_defect, 1'b0);
        check("R1 sts", mm_sts, 1'b0);
        check("R1 irq", mm_irq, 1'b0);

        // R2 R3 R4 R5 R9 R10: sweep architecture x direction x nibble, N=3
        cfg_short = 1'b1;
        for (int a = 0; a < 2; a++) begin
            for (int d = 0; d < 2; d++) begin
                for (int n = 0; n < 16; n++) begin
                    cfg_arch = a[0]; cfg_dir = d[0];
                    do_reset();
                    frame(n[3:0], 1'b0, 1'b0);
                    frame(n[3:0], 1'b0, 1'b0);
                    check("R5 early", mm_defect, 1'b0);
                    frame(n[3:0], 1'b0, 1'b0);
                    check("R2/R3/R4 defect", mm_defect, exp_mm(n[3:0], a[0], d[0]));
                    check("R9 sts", mm_sts, exp_mm(n[3:0], a[0], d[0]));
                    check("R10 irq", mm_irq, exp_mm(n[3:0], a[0], d[0]));
                end
            end
        end

        // R5 five-frame persistence
        cfg_arch = 1'b0; cfg_dir = 1'b0; cfg_short = 1'b0;
        do_reset();
        for (int i = 0; i < 4; i++) frame(4'h4, 1'b0, 1'b0);
        check("R5 long 4 frames", mm_defect, 1'b0);
        frame(4'h4, 1'b0, 1'b0);
        check("R5 long 5th frame", mm_defect, 1'b1);

        // R6 interrupted run
        cfg_short = 1'b1;
        do_reset();
        frame(4'h4, 1'b0, 1'b0);
        frame(4'h4, 1'b0, 1'b0);
        frame(4'h5, 1'b0, 1'b0);
        frame(4'h4, 1'b0, 1'b0);
        frame(4'h4, 1'b0, 1'b0);
        check("R6 restart", mm_defect, 1'b0);
        // R8 non-strobe cycles with mismatch data
        @(negedge clk);
        k2_byte = 8'hA4;
        repeat (6) @(negedge clk);
        k2_byte = 8'h00;
        check("R8 no strobe", mm_defect, 1'b0);
        frame(4'h4, 1'b0, 1'b0);
        check("R6 declare after restart", mm_defect, 1'b1);

        // R7 removal, with AIS/RDI codes counting clean (R4)
        pulse(1'b1, 1'b0);
        check("R11 read clears", mm_sts, 1'b0);
        frame(4'h7, 1'b0, 1'b0);
        frame(4'h6, 1'b0, 1'b0);
        check("R7 still set", mm_defect, 1'b1);
        frame(4'h4, 1'b0, 1'b0);
        frame(4'h7, 1'b0, 1'b0);
        frame(4'h6, 1'b0, 1'b0);
        check("R6 clean restart", mm_defect, 1'b1);
        frame(4'h5, 1'b0, 1'b0);
        check("R7 removed", mm_defect, 1'b0);
        check("R9 sts on removal", mm_sts, 1'b1);

        // R10 mask
        irq_mask = 1'b1;
        #1;
        check("R10 masked", mm_irq, 1'b0);
        irq_mask = 1'b0;
        #1;
        check("R10 unmasked", mm_irq, 1'b1);

        // R11 clear modes
        clr_on_rd = 1'b1;
        pulse(1'b0, 1'b1);
        check("R11 write ignored", mm_sts, 1'b1);
        clr_on_rd = 1'b0;
        pulse(1'b1, 1'b0);
        check("R11 read ignored", mm_sts, 1'b1);
        pulse(1'b0, 1'b1);
        check("R11 write clears", mm_sts, 1'b0);

        // R12 set and clear on one edge
        clr_on_rd = 1'b1;
        frame(4'hC, 1'b0, 1'b0);
        frame(4'hC, 1'b0, 1'b0);
        frame(4'hC, 1'b0, 1'b0);
        check("R12 setup defect", mm_defect, 1'b1);
        frame(4'h5, 1'b0, 1'b0);
        frame(4'h5, 1'b0, 1'b0);
        frame(4'h5, 1'b1, 1'b0);
        check("R12 defect fell", mm_defect, 1'b0);
        check("R12 set wins", mm_sts, 1'b1);
        pulse(1'b1, 1'b0);
        check("R12 later read clears", mm_sts, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule